// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the port-to-port doorbell flags that sit beside a shared 1K-word memory with two independent access ports, called left and right. The two highest addresses serve as mailboxes: the top word belongs to the left port and the word below it belongs to the right port. A port rings its partner by writing the partner's mailbox. That write pulls the partner's active-low interrupt output low. The partner acknowledges by reading its own mailbox, and that read releases the flag.

The block does not look at the memory data. Each cycle of a system clock it samples each port's select, direction strobe, output enable and address. Every flag is a register, so a qualifying access changes the flag outputs on the rising clock edge that samples it. The flag that a port drives always describes mail waiting for that same port. The open-drain drive of a board-level flag is outside the block, and the block presents each flag as a plain active-low logic level.

Top module: `mbox_irq_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, both `l_irq_n` and `r_irq_n` are 1.
- R2: A left-port write is `l_sel_n`=0 and `l_rd`=0. A left-port write to address 0x3FE makes `r_irq_n` 0 from the next rising edge.
- R3: A right-port write is `r_sel_n`=0 and `r_rd`=0. A right-port write to address 0x3FF makes `l_irq_n` 0 from the next rising edge.
- R4: A left-port read is `l_sel_n`=0, `l_oe_n`=0 and `l_rd`=1. A left-port read of 0x3FF, with no right-port write to 0x3FF in the same cycle, makes `l_irq_n` 1 from the next edge.
- R5: A right-port read is `r_sel_n`=0, `r_oe_n`=0 and `r_rd`=1. A right-port read of 0x3FE, with no left-port write to 0x3FE in the same cycle, makes `r_irq_n` 1 from the next edge.
- R6: A write with select high, or a write to any address other than the partner's mailbox, leaves both flags unchanged.
- R7: A mailbox read with output enable high or with select high does not clear the flag.
- R8: Writing a mailbox whose flag is already active keeps the flag active. When a flag is set and cleared in the same cycle, it ends active (0).
- R9: A port writing its own mailbox, or reading its partner's mailbox, leaves both flags unchanged.
- R10: If a cycle contains no set and no clear for a flag, that flag keeps its value on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left port select, active low |
| l_rd | input | 1 | Left direction strobe: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left port word address |
| r_sel_n | input | 1 | Right port select, active low |
| r_rd | input | 1 | Right direction strobe: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| l_irq_n | output | 1 | Left mail-pending flag, active low |
| r_irq_n | output | 1 | Right mail-pending flag, active low |

## Verification
Directed accesses separate the cases that differ by a single control: a mailbox write with select raised, a mailbox read with output enable raised, and an access to the neighbouring address 0x3FD. These show that each qualifier and the exact address decode are all needed. Cross-cases, such as a port writing its own mailbox or reading its partner's, show that the set and clear paths are steered to the correct flag. A same-cycle set and clear shows which one has priority. After the directed cases, seeded random traffic biased toward the two mailbox addresses mixes every control combination on both ports, so simultaneous events on both flags happen often, and each cycle is compared against a reference model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // decoded mailbox events for one port in one cycle
    typedef struct packed {
        logic post;   // write that targets the partner's mailbox
        logic ack;    // read of this port's own mailbox
    } mbox_evt_t;

    // registered state of one mail-pending flag
    typedef struct packed {
        logic pending;
    } flag_state_t;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              sel_n,
    input  logic              rd,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output mbox_evt_t         evt
);

    logic wr_cyc;
    logic rd_cyc;

    always_comb begin
        wr_cyc   = !sel_n && !rd;
        rd_cyc   = !sel_n && rd && !oe_n;
        evt.post = wr_cyc && (addr == PEER_BOX);
        evt.ack  = rd_cyc && (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_n
);

    flag_state_t st_d;
    flag_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (set_req) begin
            st_d.pending = 1'b1;
        end else if (clr_req) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_n = !st_q.pending;

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_rd,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_sel_n,
    input  logic              r_rd,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_L = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_R = BOX_L - ADDR_W'(1);

    logic [NUM_PORTS-1:0]             sel_n_v;
    logic [NUM_PORTS-1:0]             rd_v;
    logic [NUM_PORTS-1:0]             oe_n_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    mbox_evt_t [NUM_PORTS-1:0]        evt_v;
    logic [NUM_PORTS-1:0]             irq_n_v;

    assign sel_n_v = {r_sel_n, l_sel_n};
    assign rd_v    = {r_rd, l_rd};
    assign oe_n_v  = {r_oe_n, l_oe_n};
    assign addr_v  = {r_addr, l_addr};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == PORT_L) ? BOX_L : BOX_R;
        localparam logic [ADDR_W-1:0] PEER = (p == PORT_L) ? BOX_R : BOX_L;
        localparam int unsigned       OTHER = NUM_PORTS - 1 - p;

        mbox_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (OWN),
            .PEER_BOX(PEER)
        ) u_dec (
            .sel_n(sel_n_v[p]),
            .rd   (rd_v[p]),
            .oe_n (oe_n_v[p]),
            .addr (addr_v[p]),
            .evt  (evt_v[p])
        );

        // flag p is raised by the partner's post and dropped by own ack
        mbox_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_req(evt_v[OTHER].post),
            .clr_req(evt_v[p].ack),
            .flag_n (irq_n_v[p])
        );
    end

    assign l_irq_n = irq_n_v[PORT_L];
    assign r_irq_n = irq_n_v[PORT_R];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_sel_n,
    input logic              l_rd,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_sel_n,
    input logic              r_rd,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_W  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_W = TOP_W - ADDR_W'(1);

    logic ring_l, ring_r, seen_l, seen_r;
    assign ring_l = !r_sel_n && !r_rd && (r_addr == TOP_W);
    assign ring_r = !l_sel_n && !l_rd && (l_addr == NEXT_W);
    assign seen_l = !l_sel_n && l_rd && !l_oe_n && (l_addr == TOP_W);
    assign seen_r = !r_sel_n && r_rd && !r_oe_n && (r_addr == NEXT_W);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (l_irq_n && r_irq_n));

    // R2
    ring_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_r |=> !r_irq_n);

    // R3
    ring_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_l |=> !l_irq_n);

    // R4
    ack_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_l && !ring_l) |=> l_irq_n);

    // R5
    ack_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_r && !ring_r) |=> r_irq_n);

    // R10
    hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_l && !seen_l) |=> $stable(l_irq_n));

    // R10
    hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_r && !seen_r) |=> $stable(r_irq_n));

endmodule

bind mbox_irq_top mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_sel_n(l_sel_n),
    .l_rd   (l_rd),
    .l_oe_n (l_oe_n),
    .l_addr (l_addr),
    .r_sel_n(r_sel_n),
    .r_rd   (r_rd),
    .r_oe_n (r_oe_n),
    .r_addr (r_addr),
    .l_irq_n(l_irq_n),
    .r_irq_n(r_irq_n)
);

// File: tb/sim_mbox_irq_top.sv
`timescale 1ns/1ps
module sim_mbox_irq_top;

    localparam int unsigned AW = 10;
    localparam logic [AW-1:0] MB_L = 10'h3FF;
    localparam logic [AW-1:0] MB_R = 10'h3FE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sel_n = 1'b1, l_rd = 1'b1, l_oe_n = 1'b1;
    logic          r_sel_n = 1'b1, r_rd = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_irq_n, r_irq_n;

    int n_run  = 0;
    int n_fail = 0;
    bit exp_l  = 1'b0;   // 1 = left mail pending
    bit exp_r  = 1'b0;   // 1 = right mail pending
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mbox_irq_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_rd(l_rd), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .r_sel_n(r_sel_n), .r_rd(r_rd), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    function automatic bit is_wr(bit sel_n, bit rd);
        return !sel_n && !rd;
    endfunction

    function automatic bit is_rd(bit sel_n, bit rd, bit oe_n);
        return !sel_n && rd && !oe_n;
    endfunction

    function automatic bit next_flag(bit cur, bit set, bit clr);
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    task automatic check(string tag, logic got, logic want, string what);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s got=%b want=%b", tag, what, got, want);
        end
    endtask

    // one access cycle on both ports, then compare both flags after the edge
    task automatic cyc(bit ls, bit lr, bit lo, logic [AW-1:0] la,
                       bit rs, bit rr, bit ro, logic [AW-1:0] ra, string tag);
        bit set_l, clr_l, set_r, clr_r;
        @(negedge clk);
        l_sel_n = ls; l_rd = lr; l_oe_n = lo; l_addr = la;
        r_sel_n = rs; r_rd = rr; r_oe_n = ro; r_addr = ra;
        set_r = is_wr(ls, lr) && (la == MB_R);
        set_l = is_wr(rs, rr) && (ra == MB_L);
        clr_l = is_rd(ls, lr, lo) && (la == MB_L);
        clr_r = is_rd(rs, rr, ro) && (ra == MB_R);
        exp_l = next_flag(exp_l, set_l, clr_l);
        exp_r = next_flag(exp_r, set_r, clr_r);
        @(posedge clk);
        #1;
        check(tag, l_irq_n, !exp_l, "l_irq_n");
        check(tag, r_irq_n, !exp_r, "r_irq_n");
    endtask

    localparam logic [AW-1:0] Z = '0;

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog got=hung want=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7177));
        #12;
        check("R1", l_irq_n, 1'b1, "l_irq_n in reset");
        check("R1", r_irq_n, 1'b1, "r_irq_n in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", l_irq_n, 1'b1, "l_irq_n after release");
        check("R1", r_irq_n, 1'b1, "r_irq_n after release");

        // R6: gated or misaddressed writes
        cyc(1,0,1,MB_R, 1,1,1,Z, "R6");          // select high
        cyc(0,0,1,10'h3FD, 1,1,1,Z, "R6");       // neighbour address
        cyc(1,1,1,Z, 0,0,1,10'h3FD, "R6");
        // R9: own mailbox write, partner mailbox read
        cyc(0,0,1,MB_L, 0,0,1,MB_R, "R9");
        // R2: left rings right
        cyc(0,0,1,MB_R, 1,1,1,Z, "R2");
        // R9: left reads right's box, right reads left's box: no clear
        cyc(0,1,0,MB_R, 0,1,0,MB_L, "R9");
        // R7: right read with oe high, then with select high
        cyc(1,1,1,Z, 0,1,1,MB_R, "R7");
        cyc(1,1,1,Z, 1,1,0,MB_R, "R7");
        // R5: right acknowledges
        cyc(1,1,1,Z, 0,1,0,MB_R, "R5");
        // R3: right rings left, write with oe low still a write
        cyc(1,1,1,Z, 0,0,0,MB_L, "R3");
        // R8: ring again while pending
        cyc(1,1,1,Z, 0,0,1,MB_L, "R8");
        // R10: idle keeps state
        cyc(1,1,1,Z, 1,1,1,Z, "R10");
        // R8: set and clear collide on left flag, set wins
        cyc(0,1,0,MB_L, 0,0,1,MB_L, "R8");
        // R4: left acknowledges
        cyc(0,1,0,MB_L, 1,1,1,Z, "R4");
        // R8: collide on right flag from an idle flag
        cyc(0,0,1,MB_R, 0,1,0,MB_R, "R8");
        cyc(1,1,1,Z, 0,1,0,MB_R, "R5");

        // R10: seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] la, ra;
            int unsigned k;
            k = $urandom % 4;
            la = (k == 0) ? MB_L : (k == 1) ? MB_R : (k == 2) ? 10'h3FD : AW'($urandom);
            k = $urandom % 4;
            ra = (k == 0) ? MB_L : (k == 1) ? MB_R : (k == 2) ? 10'h3FD : AW'($urandom);
            cyc(1'($urandom), 1'($urandom), 1'($urandom), la,
                1'($urandom), 1'($urandom), 1'($urandom), ra, "R10");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule